// File: doc/BRIEF.md
# Multi-threshold pulse-height counter

This block performs coarse pulse-height analysis for a bank of detector channels. Every channel provides one bit for each of a fixed set of comparators. All channels share the same threshold levels, in increasing order. Each comparator bit is synchronised to the clock. The block turns each rising edge of a bit into one count event and adds it to a counter that belongs to that channel and threshold. A pulse that crosses several thresholds adds one count to each of them. A host can later form a coarse spectrum from these counts. It does this outside the block by taking the difference between neighbouring thresholds.

Counting runs only while a count-enable gate is high. A clear input zeroes every counter in a single cycle. To read the counts out, a start pulse copies every counter and its saturation flag into a snapshot at one clock edge. The snapshot then streams out as valid/ready beats. Each beat carries the channel and threshold index. Counting continues during the stream, and the values being sent are not disturbed.

Top module: `mtph_counter`

## Requirements
- R1: Comparator bit `ch*N_TH + th` of `cmp_i` belongs to channel `ch` and threshold `th`, where threshold 0 is the lowest. A 0-to-1 transition of that bit adds exactly one count to its counter. This holds however long the bit then stays high. Each level must last at least one clock.
- R2: The counters are independent. A pulse that raises the bits of thresholds 0 to k-1 of a channel adds one count to each of those k counters and none to the others. Edges on many bits in the same cycle are all counted.
- R3: Outside of a clear, a counter changes only by +1 per cycle, and it never decreases.
- R4: A counter holds at all-ones instead of wrapping. Its saturation flag is set when an event arrives while the counter already holds all-ones. The flag stays set until a clear.
- R5: While `count_en_i` is low, edges are discarded. They are not deferred, and the counters keep their values.
- R6: `clear_i` zeroes every counter and saturation flag at the next edge. An event in the same cycle is lost. A clear does not alter a snapshot that was already taken, including one taken at the same edge.
- R7: `rd_start_i` while no readout is running captures, at that edge, the counter values and flags as they were before any update at that edge. Beats start in the next cycle. `rd_start_i` during a readout is ignored.
- R8: Beats run channel 0 to `N_CH-1`. Within a channel they run threshold 0 to `N_TH-1`, and `rd_chan_o`/`rd_thr_o` carry the indices. `rd_last_o` marks the final beat, after which `rd_valid_o` falls.
- R9: A beat with `rd_valid_o` high and `rd_ready_i` low is held unchanged. The stream advances only on a handshake.
- R10: After reset all counters and flags are zero and `rd_valid_o` is low. Events during a readout go into the live counters and appear in the next readout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_i | input | N_CH*N_TH | Comparator levels, bit ch*N_TH+th |
| count_en_i | input | 1 | Count gate |
| clear_i | input | 1 | Zero all counters and flags |
| rd_start_i | input | 1 | Take snapshot and start streaming |
| rd_ready_i | input | 1 | Consumer accepts the current beat |
| rd_valid_o | output | 1 | Beat valid |
| rd_count_o | output | CW | Snapshot count |
| rd_sat_o | output | 1 | Snapshot saturation flag |
| rd_chan_o | output | $clog2(N_CH) | Channel index of beat |
| rd_thr_o | output | $clog2(N_TH) | Threshold index of beat |
| rd_last_o | output | 1 | Final beat of the stream |

## Verification
The assertions check four things on every cycle: every counter moves by at most one step, counters freeze while the gate is low, a set flag implies a full counter, and the stream is held while stalled and runs without gaps until its last beat. Some behaviour shows only in the bench's scenarios, through a behavioural model compared on every clock. This covers the exact count for each pulse height, a long level counted once, saturation after many pulses, a clear or a second start during a stream, and a clear at the same edge as a start.

// File: rtl/mtph_counter.sv
module mtph_counter #(
  parameter int N_CH = 32,
  parameter int N_TH = 5,
  parameter int CW   = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_CH*N_TH-1:0]    cmp_i,
  input  logic                    count_en_i,
  input  logic                    clear_i,
  input  logic                    rd_start_i,
  input  logic                    rd_ready_i,
  output logic                    rd_valid_o,
  output logic [CW-1:0]           rd_count_o,
  output logic                    rd_sat_o,
  output logic [$clog2(N_CH)-1:0] rd_chan_o,
  output logic [$clog2(N_TH)-1:0] rd_thr_o,
  output logic                    rd_last_o
);
  localparam int N_TOT = N_CH * N_TH;
  localparam int CHW   = $clog2(N_CH);
  localparam int THW   = $clog2(N_TH);
  localparam int IW    = $clog2(N_TOT);
  localparam logic [CW-1:0] FULL = {CW{1'b1}};

  logic [N_TOT-1:0] s1_q, s2_q, s3_q, hit;
  logic [CW-1:0]    cnt_q  [N_TOT];
  logic [CW-1:0]    snap_q [N_TOT];
  logic [N_TOT-1:0] sat_q, snap_sat_q;
  logic             busy_q;
  logic [CHW-1:0]   ch_q;
  logic [THW-1:0]   th_q;
  logic [IW-1:0]    idx;
  logic             start, beat, at_last;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1_q <= '0; s2_q <= '0; s3_q <= '0;
    end else begin
      s1_q <= cmp_i; s2_q <= s1_q; s3_q <= s2_q;
    end

  assign hit = s2_q & ~s3_q & {N_TOT{count_en_i}};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < N_TOT; i++) cnt_q[i] <= '0;
      sat_q <= '0;
    end else if (clear_i) begin
      for (int i = 0; i < N_TOT; i++) cnt_q[i] <= '0;
      sat_q <= '0;
    end else begin
      for (int i = 0; i < N_TOT; i++)
        if (hit[i]) begin
          if (cnt_q[i] == FULL) sat_q[i] <= 1'b1;
          else                  cnt_q[i] <= cnt_q[i] + 1'b1;
        end
    end

  assign start   = rd_start_i & ~busy_q;
  assign beat    = busy_q & rd_ready_i;
  assign at_last = (ch_q == CHW'(N_CH-1)) && (th_q == THW'(N_TH-1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < N_TOT; i++) snap_q[i] <= '0;
      snap_sat_q <= '0;
    end else if (start) begin
      for (int i = 0; i < N_TOT; i++) snap_q[i] <= cnt_q[i];
      snap_sat_q <= sat_q;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy_q <= 1'b0; ch_q <= '0; th_q <= '0;
    end else if (start) begin
      busy_q <= 1'b1; ch_q <= '0; th_q <= '0;
    end else if (beat) begin
      if (at_last) busy_q <= 1'b0;
      else if (th_q == THW'(N_TH-1)) begin
        th_q <= '0; ch_q <= ch_q + 1'b1;
      end else th_q <= th_q + 1'b1;
    end

  assign idx        = IW'(ch_q) * IW'(N_TH) + IW'(th_q);
  assign rd_valid_o = busy_q;
  assign rd_count_o = snap_q[idx];
  assign rd_sat_o   = snap_sat_q[idx];
  assign rd_chan_o  = ch_q;
  assign rd_thr_o   = th_q;
  assign rd_last_o  = busy_q & at_last;

  for (genvar g = 0; g < N_TOT; g++) begin : g_chk
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !clear_i |=> (cnt_q[g] == $past(cnt_q[g]) || cnt_q[g] == $past(cnt_q[g]) + CW'(1)));
    p_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!count_en_i && !clear_i) |=> $stable(cnt_q[g]));
    p_sat_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
      sat_q[g] |-> cnt_q[g] == FULL);
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_count_o) &&
      $stable(rd_sat_o) && $stable(rd_chan_o) && $stable(rd_thr_o)));
  p_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && rd_ready_i && !rd_last_o) |=> rd_valid_o);
  p_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && rd_ready_i && rd_last_o) |=> !rd_valid_o);
endmodule

// File: tb/mtph_counter_tb_top.sv
module mtph_counter_tb_top;
  localparam int NC = 32, NT = 5, CW = 4;
  localparam int NTOT = NC * NT;
  localparam int FULL = (1 << CW) - 1;

  logic clk = 0, rst_n = 0;
  logic [NTOT-1:0] cmp = '0;
  logic en = 0, clr = 0, start = 0, ready = 1;
  logic rd_valid, rd_sat, rd_last;
  logic [CW-1:0] rd_count;
  logic [$clog2(NC)-1:0] rd_chan;
  logic [$clog2(NT)-1:0] rd_thr;

  int n_cmp = 0, n_bad = 0;
  int stall_mode = 0, cyc = 0;
  bit done = 0;

  int m_cnt [NTOT];
  bit m_sat [NTOT];
  int s_cnt [NTOT];
  bit s_sat [NTOT];
  bit m_busy = 0;
  int m_idx = 0;
  logic [NTOT-1:0] hist [$];

  always #10 clk = ~clk;

  mtph_counter #(.N_CH(NC), .N_TH(NT), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmp_i(cmp), .count_en_i(en), .clear_i(clr),
    .rd_start_i(start), .rd_ready_i(ready), .rd_valid_o(rd_valid),
    .rd_count_o(rd_count), .rd_sat_o(rd_sat), .rd_chan_o(rd_chan),
    .rd_thr_o(rd_thr), .rd_last_o(rd_last));

  // Behavioural reference: inputs seen two edges ago against three edges ago.
  always @(posedge clk) begin
    if (!rst_n) begin
      hist = '{NTOT'(0), NTOT'(0), NTOT'(0)};
      m_busy = 0; m_idx = 0;
      foreach (m_cnt[i]) begin m_cnt[i] = 0; m_sat[i] = 0; s_cnt[i] = 0; s_sat[i] = 0; end
    end else begin
      logic [NTOT-1:0] ev;
      ev = hist[1] & ~hist[2];
      if (start && !m_busy) begin
        foreach (m_cnt[i]) begin s_cnt[i] = m_cnt[i]; s_sat[i] = m_sat[i]; end
        m_busy = 1; m_idx = 0;
      end else if (m_busy && ready) begin
        if (m_idx == NTOT - 1) m_busy = 0; else m_idx++;
      end
      foreach (m_cnt[i])
        if (clr) begin m_cnt[i] = 0; m_sat[i] = 0; end
        else if (en && ev[i]) begin
          if (m_cnt[i] == FULL) m_sat[i] = 1; else m_cnt[i]++;
        end
      hist.push_front(cmp);
      void'(hist.pop_back());
    end
  end

  always @(negedge clk) begin
    cyc++;
    ready <= (stall_mode == 0) ? 1'b1 : ((cyc % 3) != 1);
    if (rst_n && !done) begin
      n_cmp++;
      if (rd_valid !== m_busy) begin
        n_bad++; $display("FAIL R7 valid: actual %0b expected %0b", rd_valid, m_busy);
      end else if (m_busy) begin
        n_cmp++;
        if (rd_chan != m_idx / NT || rd_thr != m_idx % NT || rd_last != (m_idx == NTOT - 1)) begin
          n_bad++; $display("FAIL R8 tag: actual ch%0d th%0d last%0b expected ch%0d th%0d last%0b",
            rd_chan, rd_thr, rd_last, m_idx / NT, m_idx % NT, m_idx == NTOT - 1);
        end
        n_cmp++;
        if (int'(rd_count) != s_cnt[m_idx]) begin
          n_bad++; $display("FAIL R2 count idx %0d: actual %0d expected %0d", m_idx, rd_count, s_cnt[m_idx]);
        end
        n_cmp++;
        if (rd_sat != s_sat[m_idx]) begin
          n_bad++; $display("FAIL R4 flag idx %0d: actual %0b expected %0b", m_idx, rd_sat, s_sat[m_idx]);
        end
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(int ch, int height, int width);
    @(negedge clk);
    for (int t = 0; t < height; t++) cmp[ch*NT + t] = 1'b1;
    idle(width);
    for (int t = 0; t < NT; t++) cmp[ch*NT + t] = 1'b0;
    idle(2);
  endtask

  task automatic kick();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic readout();
    kick();
    while (m_busy) @(negedge clk);
    idle(2);
  endtask

  initial begin
    idle(3); rst_n = 1; idle(4);
    readout();                                 // R10 reset state streams zeros
    en = 1;
    pulse(0, 5, 3); pulse(3, 2, 1); pulse(31, 1, 2);   // R1 R2 heights
    pulse(7, 3, 1); pulse(7, 5, 4);
    @(negedge clk); cmp = '1; idle(2); cmp = '0; idle(3);  // R2 all at once
    @(negedge clk); cmp[50] = 1; idle(30); cmp[50] = 0; idle(3);  // R1 long level
    idle(4); readout();
    en = 0; pulse(5, 5, 2); pulse(6, 4, 1);    // R5 gate low
    idle(3); en = 1; idle(3); readout();
    stall_mode = 1;                            // R9 stalls, R10 events during readout
    kick(); pulse(1, 4, 2); kick();            // R7 second start ignored
    idle(40); @(negedge clk); clr = 1; @(negedge clk); clr = 0;  // R6 clear mid-stream
    while (m_busy) @(negedge clk);
    pulse(9, 2, 1); idle(4); readout();
    for (int k = 0; k < 20; k++) pulse(2, 2, 1);  // R4 saturation
    idle(4); readout();
    @(negedge clk); clr = 1; start = 1;        // R6 R7 same edge
    @(negedge clk); clr = 0; start = 0;
    pulse(12, 3, 1);                           // R10 counted during stream
    while (m_busy) @(negedge clk);
    stall_mode = 0; idle(4); readout();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    done = 1; n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule